// File: doc/BRIEF.md
# UART Register Front End with Receive Queue

This block is the register side of a serial port on an APB slave. It decodes a small register window and holds three things: a control word, a status word built from live state, and a queue of received bytes. A byte-wide receive input with a one-cycle valid fills the queue. The host drains the queue by reading the data register. A host write to the data register sends the low byte out on a one-cycle transmit strobe. A single interrupt output pulses for one cycle when a byte arrives or leaves, as long as the matching interrupt enable is set.

Shifting, baud timing, parity, flow control and loopback are handled elsewhere. Their control bits are only held in the control word and read back. The APB side never inserts wait states and never reports an error. Only the low eight bits of the address are decoded, so the window repeats every 256 bytes.

Top module: `uart_apb_front`

## Requirements
- R1: After reset the control word reads 0x0000_0000. The status word reads 0x0000_0006, meaning only bit 1 (transmit shifter empty) and bit 2 (transmit queue empty) are set. The receive queue is empty, so a data read returns 0.
- R2: A receive byte (rx_valid high for one cycle) is stored only while control bit 0 (receive enable) is set. Storing a byte makes status bit 0 (data ready) read 1.
- R3: When a byte is stored and control bit 2 (receive interrupt enable) is set, irq is high for exactly the one cycle after the storing edge. A byte that is not stored raises no interrupt.
- R4: A read of the data register, at byte offset 0x00 or 0x03, returns the oldest stored byte in bits 7:0 and removes it. Status bit 0 reads 0 once the queue is empty. A data read of an empty queue returns 0.
- R5: A write to the data register, at offset 0x00 or 0x03, while control bit 1 (transmit enable) is set drives tx_strobe high for the one cycle after the write edge, with tx_byte equal to pwdata[7:0]. With the bit clear, or for writes to other registers, tx_strobe stays low.
- R6: The status register at offset 0x04 is read-only, and a write to it changes nothing that can be read back.
- R7: The control register at offset 0x08 stores all 32 bits of a write and reads them back unchanged.
- R8: The scaler register at offset 0x0C reads 0 and ignores writes. Every other offset outside 0x00, 0x03, 0x04 and 0x08 reads 0, including 0x10. Address bits above bit 7 are ignored.
- R9: A byte that arrives while receive is enabled and the queue is full is dropped, and it sets status bit 4 (overrun). Bit 4 stays set until reset.
- R10: Status bit 8 is set while the queue holds at least DEPTH/2 bytes. Status bit 10 is set while it holds exactly DEPTH bytes. Status bits 3, 5, 6, 7, 9 and 11 to 31 read 0.
- R11: pready is always 1 and pslverr is always 0.
- R12: When a byte is sent on tx_strobe and control bit 3 (transmit interrupt enable) is set, irq is high for exactly the one cycle after the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | ADDR_W | APB byte address; only bits 7:0 are decoded |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Always 0 |
| rx_valid | input | 1 | Receive byte present this cycle |
| rx_byte | input | 8 | Received byte |
| tx_strobe | output | 1 | One-cycle transmit byte strobe |
| tx_byte | output | 8 | Byte being transmitted |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench uses a four-deep queue. It fills the queue one byte at a time and checks the half and full bits at every occupancy. A threshold that is off by one would set bit 8 a byte early or a byte late. It then pushes into the full queue, which catches a design that wraps its write pointer and overwrites the oldest byte, or that forgets to set overrun or lets it clear. The drain alternates offsets 0x00 and 0x03 and compares the bytes against the order they were pushed in. A decoder that misses the byte-3 alias, or a queue that pops twice per read, returns the wrong byte there. A sweep over the whole window checks that the read-only status, the inert scaler and the aliased upper addresses never leak write data or nonzero values. It also checks that enable and interrupt-enable gating stop a strobe or a pulse when they should, and that each pulse lasts only one cycle.

// File: rtl/uart_apb_front_pkg.sv
package uart_apb_front_pkg;

   // window size in bytes; offsets at or beyond it read zero
   localparam int unsigned WINDOW_BYTES = 20;

   // register offsets within the decoded low address byte
   localparam logic [7:0] OFF_DATA      = 8'h00;
   localparam logic [7:0] OFF_DATA_BYTE = 8'h03;
   localparam logic [7:0] OFF_STATUS    = 8'h04;
   localparam logic [7:0] OFF_CONTROL   = 8'h08;
   localparam logic [7:0] OFF_SCALER    = 8'h0C;

   // status word bit positions
   localparam int unsigned SB_RDY      = 0;
   localparam int unsigned SB_TSH_MT   = 1;
   localparam int unsigned SB_TQ_MT    = 2;
   localparam int unsigned SB_BREAK    = 3;
   localparam int unsigned SB_OVR      = 4;
   localparam int unsigned SB_PAR      = 5;
   localparam int unsigned SB_FRAME    = 6;
   localparam int unsigned SB_TQ_HALF  = 7;
   localparam int unsigned SB_RQ_HALF  = 8;
   localparam int unsigned SB_TQ_FULL  = 9;
   localparam int unsigned SB_RQ_FULL  = 10;

   // control word bit positions used by this block's logic
   localparam int unsigned CB_RX_EN = 0;
   localparam int unsigned CB_TX_EN = 1;
   localparam int unsigned CB_RX_IE = 2;
   localparam int unsigned CB_TX_IE = 3;

   typedef struct packed {
      logic data;
      logic status;
      logic control;
      logic scaler;
   } reg_sel_t;

endpackage

// File: rtl/uart_apb_front_rxq.sv
module uart_apb_front_rxq #(
   parameter int unsigned DEPTH = 16,
   parameter int unsigned DW    = 8,
   localparam int unsigned AW   = $clog2(DEPTH),
   localparam int unsigned CW   = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [DW-1:0] din,
   input  logic          pop,
   output logic [DW-1:0] dout,
   output logic [CW-1:0] count,
   output logic          full,
   output logic          empty
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("uart_apb_front_rxq: DEPTH must be a power of two of at least 2");
   end
   if (DW < 1) begin : g_bad_width
      $error("uart_apb_front_rxq: DW must be positive");
   end

   logic [DW-1:0] store [DEPTH];
   logic [AW-1:0] wr_ptr;
   logic [AW-1:0] rd_ptr;

   assign full  = (count == CW'(DEPTH));
   assign empty = (count == '0);
   assign dout  = store[rd_ptr];

   always_ff @(posedge clk) begin
      if (push) begin
         store[wr_ptr] <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push) begin
            wr_ptr <= wr_ptr + AW'(1);
         end
         if (pop) begin
            rd_ptr <= rd_ptr + AW'(1);
         end
         case ({push, pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

   // R9: the front end must never push into a full queue
   assert_no_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && full));

   // R4: the front end must never pop an empty queue
   assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(pop && empty));

   // R4: popping the last byte leaves the queue empty
   assert_drain_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && count == CW'(1)) |=> empty);

endmodule

// File: rtl/uart_apb_front_decode.sv
module uart_apb_front_decode
   import uart_apb_front_pkg::*;
(
   input  logic [7:0] offset,
   output reg_sel_t   sel
);

   logic in_window;

   assign in_window = (32'(offset) < WINDOW_BYTES);

   always_comb begin
      sel = '0;
      if (in_window) begin
         sel.data    = (offset == OFF_DATA) || (offset == OFF_DATA_BYTE);
         sel.status  = (offset == OFF_STATUS);
         sel.control = (offset == OFF_CONTROL);
         sel.scaler  = (offset == OFF_SCALER);
      end
   end

   // R8: at most one register is selected for any offset
   always_comb begin
      assert_one_sel_R8: assert ($onehot0(sel));
   end

endmodule

// File: rtl/uart_apb_front_stat.sv
module uart_apb_front_stat
   import uart_apb_front_pkg::*;
#(
   parameter int unsigned DEPTH = 16,
   localparam int unsigned CW   = $clog2(DEPTH) + 1
) (
   input  logic [CW-1:0] rxq_count,
   input  logic          overrun,
   output logic [31:0]   word
);

   localparam logic [CW-1:0] HALF_MARK = CW'(DEPTH / 2);
   localparam logic [CW-1:0] FULL_MARK = CW'(DEPTH);

   always_comb begin
      word             = '0;
      word[SB_RDY]     = (rxq_count != '0);
      word[SB_TSH_MT]  = 1'b1;
      word[SB_TQ_MT]   = 1'b1;
      word[SB_BREAK]   = 1'b0;
      word[SB_OVR]     = overrun;
      word[SB_PAR]     = 1'b0;
      word[SB_FRAME]   = 1'b0;
      word[SB_TQ_HALF] = 1'b0;
      word[SB_RQ_HALF] = (rxq_count >= HALF_MARK);
      word[SB_TQ_FULL] = 1'b0;
      word[SB_RQ_FULL] = (rxq_count == FULL_MARK);
   end

endmodule

// File: rtl/uart_apb_front.sv
module uart_apb_front
   import uart_apb_front_pkg::*;
#(
   parameter int unsigned ADDR_W = 12,
   parameter int unsigned DEPTH  = 16,
   localparam int unsigned CW    = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [31:0]       pwdata,
   output logic [31:0]       prdata,
   output logic              pready,
   output logic              pslverr,
   input  logic              rx_valid,
   input  logic [7:0]        rx_byte,
   output logic              tx_strobe,
   output logic [7:0]        tx_byte,
   output logic              irq
);

   if (ADDR_W < 8) begin : g_bad_addr
      $error("uart_apb_front: ADDR_W must cover the 8 decoded address bits");
   end

   logic [31:0]   ctrl_q;
   logic          ovr_q;
   logic          tx_stb_q;
   logic [7:0]    tx_byte_q;
   logic          irq_q;

   reg_sel_t      sel;
   logic          access;
   logic          wr_access;
   logic          rd_access;
   logic          rx_take;
   logic          rx_store;
   logic          rx_drop;
   logic          q_pop;
   logic          tx_fire;
   logic [7:0]    q_head;
   logic [CW-1:0] q_count;
   logic          q_full;
   logic          q_empty;
   logic [31:0]   status_word;
   logic          unused_addr_hi;

   assign unused_addr_hi = ^{1'b0, paddr[ADDR_W-1:8]};

   uart_apb_front_decode u_decode (
      .offset (paddr[7:0]),
      .sel    (sel)
   );

   assign access    = psel && penable;
   assign wr_access = access && pwrite;
   assign rd_access = access && !pwrite;

   assign rx_take  = rx_valid && ctrl_q[CB_RX_EN];
   assign rx_store = rx_take && !q_full;
   assign rx_drop  = rx_take && q_full;
   assign q_pop    = rd_access && sel.data && !q_empty;
   assign tx_fire  = wr_access && sel.data && ctrl_q[CB_TX_EN];

   uart_apb_front_rxq #(
      .DEPTH (DEPTH),
      .DW    (8)
   ) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rx_store),
      .din   (rx_byte),
      .pop   (q_pop),
      .dout  (q_head),
      .count (q_count),
      .full  (q_full),
      .empty (q_empty)
   );

   uart_apb_front_stat #(
      .DEPTH (DEPTH)
   ) u_stat (
      .rxq_count (q_count),
      .overrun   (ovr_q),
      .word      (status_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         ovr_q     <= 1'b0;
         tx_stb_q  <= 1'b0;
         tx_byte_q <= '0;
         irq_q     <= 1'b0;
      end else begin
         if (wr_access && sel.control) begin
            ctrl_q <= pwdata;
         end
         if (rx_drop) begin
            ovr_q <= 1'b1;
         end
         tx_stb_q <= tx_fire;
         if (tx_fire) begin
            tx_byte_q <= pwdata[7:0];
         end
         irq_q <= (rx_store && ctrl_q[CB_RX_IE]) || (tx_fire && ctrl_q[CB_TX_IE]);
      end
   end

   always_comb begin
      prdata = '0;
      unique case (1'b1)
         sel.data:    prdata = q_empty ? 32'h0 : {24'h0, q_head};
         sel.status:  prdata = status_word;
         sel.control: prdata = ctrl_q;
         default:     prdata = '0;
      endcase
   end

   assign pready    = 1'b1;
   assign pslverr   = 1'b0;
   assign tx_strobe = tx_stb_q;
   assign tx_byte   = tx_byte_q;
   assign irq       = irq_q;

   // R5: the strobed byte is the low byte of the write one cycle earlier
   assert_tx_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_strobe |-> (tx_byte == $past(pwdata[7:0])));

   // R5: no strobe without an APB write in the previous cycle
   assert_tx_needs_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
      tx_strobe |-> $past(psel && penable && pwrite));

   // R2: receive bytes are not stored while receive is disabled
   assert_rx_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && !ctrl_q[CB_RX_EN] && !q_pop) |=> (q_count == $past(q_count)));

   // R9: overrun is sticky until reset
   assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_q |=> ovr_q);

   // R3 / R12: an interrupt pulse needs one of its enables set beforehand
   assert_irq_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(ctrl_q[CB_RX_IE] || ctrl_q[CB_TX_IE]));

   // R12: a transmit-only pulse comes with a strobe
   assert_irq_tx_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !$past(rx_valid)) |-> tx_strobe);

endmodule

// File: tb/uart_apb_front_bench.sv
module uart_apb_front_bench;

   localparam int unsigned ADDR_W = 12;
   localparam int unsigned DEPTH  = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              psel = 1'b0;
   logic              penable = 1'b0;
   logic              pwrite = 1'b0;
   logic [ADDR_W-1:0] paddr = '0;
   logic [31:0]       pwdata = '0;
   logic [31:0]       prdata;
   logic              pready;
   logic              pslverr;
   logic              rx_valid = 1'b0;
   logic [7:0]        rx_byte = '0;
   logic              tx_strobe;
   logic [7:0]        tx_byte;
   logic              irq;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   uart_apb_front #(
      .ADDR_W (ADDR_W),
      .DEPTH  (DEPTH)
   ) u_uart_apb_front (
      .clk       (clk),
      .rst_n     (rst_n),
      .psel      (psel),
      .penable   (penable),
      .pwrite    (pwrite),
      .paddr     (paddr),
      .pwdata    (pwdata),
      .prdata    (prdata),
      .pready    (pready),
      .pslverr   (pslverr),
      .rx_valid  (rx_valid),
      .rx_byte   (rx_byte),
      .tx_strobe (tx_strobe),
      .tx_byte   (tx_byte),
      .irq       (irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apb_wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
      @(negedge clk);
      penable = 1'b1;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
   endtask

   task automatic apb_rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
      @(negedge clk);
      penable = 1'b1;
      #1 d = prdata;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic rx_push(input logic [7:0] b);
      @(negedge clk);
      rx_valid = 1'b1; rx_byte = b;
      @(negedge clk);
      rx_valid = 1'b0;
   endtask

   function automatic logic [31:0] exp_status(input int n, input bit ovr);
      logic [31:0] s;
      s = 32'h6;
      s[0]  = (n > 0);
      s[4]  = ovr;
      s[8]  = (n >= DEPTH / 2);
      s[10] = (n == DEPTH);
      return s;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
         $finish;
      end
   end

   initial begin
      logic [31:0] rd;
      logic [31:0] exp;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state, R11 bus constants
      apb_rd(12'h008, rd); chk("R1 control after reset", rd, 32'h0);
      apb_rd(12'h004, rd); chk("R1 status after reset", rd, 32'h6);
      apb_rd(12'h000, rd); chk("R1 data read of empty queue", rd, 32'h0);
      chk("R11 pready", {31'h0, pready}, 32'h1);
      chk("R11 pslverr", {31'h0, pslverr}, 32'h0);

      // R2 byte ignored while receive disabled
      rx_push(8'h55);
      chk("R3 no irq for unstored byte", {31'h0, irq}, 32'h0);
      apb_rd(12'h004, rd); chk("R2 disabled receive leaves status", rd, 32'h6);

      // R7 control readback of several patterns
      apb_wr(12'h008, 32'hFFFF_FFFF);
      apb_rd(12'h008, rd); chk("R7 control all ones", rd, 32'hFFFF_FFFF);
      apb_wr(12'h008, 32'h8000_1A50);
      apb_rd(12'h008, rd); chk("R7 control pattern", rd, 32'h8000_1A50);
      apb_wr(12'h008, 32'h0000_0005);
      apb_rd(12'h008, rd); chk("R7 control rx on", rd, 32'h5);

      // R2 R3 R10 fill the queue byte by byte
      for (int i = 0; i < DEPTH; i++) begin
         rx_push(8'hA0 + 8'(i));
         chk("R3 irq after stored byte", {31'h0, irq}, 32'h1);
         @(negedge clk);
         chk("R3 irq lasts one cycle", {31'h0, irq}, 32'h0);
         apb_rd(12'h004, rd);
         chk("R10 R2 status while filling", rd, exp_status(i + 1, 1'b0));
      end

      // R9 overflow drops byte and sets overrun
      rx_push(8'hEE);
      chk("R3 no irq for dropped byte", {31'h0, irq}, 32'h0);
      apb_rd(12'h004, rd); chk("R9 overrun set on full", rd, exp_status(DEPTH, 1'b1));

      // R4 drain in order, alternating offsets 0x00 and 0x03
      for (int i = 0; i < DEPTH; i++) begin
         apb_rd((i % 2 == 0) ? 12'h000 : 12'h003, rd);
         chk("R4 drain order", rd, 32'hA0 + 32'(i));
         apb_rd(12'h004, rd);
         chk("R4 R10 status while draining", rd, exp_status(DEPTH - 1 - i, 1'b1));
      end
      apb_rd(12'h003, rd); chk("R4 read of empty queue", rd, 32'h0);
      apb_rd(12'h004, rd); chk("R9 overrun sticky", rd, exp_status(0, 1'b1));

      // R6 status is read-only
      apb_wr(12'h004, 32'hFFFF_FFFF);
      apb_rd(12'h004, rd); chk("R6 status write ignored", rd, exp_status(0, 1'b1));

      // R8 scaler inert; window sweep; upper address aliasing
      apb_wr(12'h00C, 32'h0000_1234);
      apb_rd(12'h00C, rd); chk("R8 scaler reads zero", rd, 32'h0);
      for (int a = 0; a < 32; a++) begin
         apb_rd(ADDR_W'(a), rd);
         exp = (a == 4) ? exp_status(0, 1'b1) : (a == 8) ? 32'h5 : 32'h0;
         chk("R8 window sweep", rd, exp);
      end
      apb_rd(12'h108, rd); chk("R8 alias above bit 7", rd, 32'h5);
      apb_rd(12'hF04, rd); chk("R8 alias status", rd, exp_status(0, 1'b1));

      // R5 transmit gated off
      apb_wr(12'h008, 32'h0000_0000);
      apb_wr(12'h000, 32'h0000_005A);
      chk("R5 no strobe while transmit disabled", {31'h0, tx_strobe}, 32'h0);

      // R5 transmit enabled, no transmit interrupt
      apb_wr(12'h008, 32'h0000_0002);
      chk("R5 control write gives no strobe", {31'h0, tx_strobe}, 32'h0);
      for (int v = 0; v < 256; v += 37) begin
         apb_wr((v % 2 == 0) ? 12'h000 : 12'h103, {24'hABCDEF, 8'(v)});
         chk("R5 strobe on data write", {31'h0, tx_strobe}, 32'h1);
         chk("R5 strobed byte", {24'h0, tx_byte}, 32'(v));
         chk("R12 no irq with transmit interrupt off", {31'h0, irq}, 32'h0);
         @(negedge clk);
         chk("R5 strobe lasts one cycle", {31'h0, tx_strobe}, 32'h0);
      end

      // R12 transmit interrupt
      apb_wr(12'h008, 32'h0000_000A);
      apb_wr(12'h000, 32'h0000_00C3);
      chk("R12 irq on transmitted byte", {31'h0, irq}, 32'h1);
      chk("R5 byte with interrupt", {24'h0, tx_byte}, 32'hC3);
      @(negedge clk);
      chk("R12 irq lasts one cycle", {31'h0, irq}, 32'h0);

      // R1 R9 second reset clears overrun and control
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      apb_rd(12'h004, rd); chk("R1 R9 status after second reset", rd, 32'h6);
      apb_rd(12'h008, rd); chk("R1 control after second reset", rd, 32'h0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
   end

endmodule